// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Result Formatting

This block is the digital half of a 10-bit successive-approximation converter. It presents a trial code to an external DAC and comparator, reads back one decision bit per conversion-clock tick, and settles the code from the most significant bit down. The finished code is then written to a 16-bit result word in one of two layouts, a one-cycle done strobe is raised, and an interrupt flag is set.

The block runs on the system clock. The conversion clock comes in as a one-cycle enable (`conv_tick`), so any divider or clock source outside the block sets the conversion rate. A conversion always takes thirteen ticks. One tick is used for synchronisation, ten resolve the bits, and two are used for settling and storing. While a conversion is in progress, further start requests are ignored. The analog comparator, sample-and-hold and references lie outside the block.

Top module: `sar_core`

## Requirements
- R1: After reset, `busy`, `done`, `irq_flag`, `dac_code` and `result` are all zero.
- R2: A `start` pulse seen while `busy` is low makes `busy` high on the next clock. `busy` then stays high until the result is stored.
- R3: Exactly 13 clocks with `conv_tick` high pass while `busy` is high. `done` is a single-cycle pulse in the cycle after the 13th tick, and `busy` is low in that same cycle.
- R4: Bits are resolved MSB first. On each deciding tick the bit under trial is kept when `cmp_ge` is 1 (input at or above the DAC level) and cleared otherwise. With a monotonic comparator, the final code equals the input level.
- R5: While busy, `dac_code` changes only on clocks where `conv_tick` is high.
- R6: With `fmt_twos` = 0 when the result is stored, `result` = {6'b0, code[9:0]} (unsigned, right-aligned).
- R7: With `fmt_twos` = 1 when the result is stored, `result` = {~code[9], code[8:0], 6'b0} (two's complement, left-aligned).
- R8: `result` holds the most recent conversion. It changes only together with `done`, and between conversions it is unaffected by `fmt_twos`, `conv_tick` or `cmp_ge`.
- R9: `irq_flag` is set when a result is stored. It is cleared by `irq_ack` or by `flag_clr`. If a store and a clear happen on the same clock, the store wins.
- R10: A `start` pulse while `busy` is high is ignored. The tick count and the result of the running conversion are unchanged, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request pulse |
| conv_tick | input | 1 | Conversion-clock enable, one system cycle per tick |
| cmp_ge | input | 1 | Comparator decision: input at or above DAC level |
| fmt_twos | input | 1 | Result layout: 0 unsigned right-aligned, 1 two's complement left-aligned |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| flag_clr | input | 1 | Software clear of the flag |
| dac_code | output | 10 | Trial code to the external DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| result | output | 16 | Latest formatted result |
| irq_flag | output | 1 | Result-ready interrupt flag |

## Verification
A wrong tick counter moves the `done` pulse away from the 13th tick. This is visible as a tick count other than 13 at the moment `done` appears. A wrong bit index or a wrong keep/clear decision in the approximation register shows up on `dac_code` within one tick, and in the final code as a mismatch against the stub's input level. Comparing against both layouts across MSB-set and MSB-clear inputs exposes a formatting fault once the conversion completes. Idle-time stimulus and mid-conversion start pulses expose a result register or sequencer that reacts when it should not.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_BITS = 2'd2,
      PH_TAIL = 2'd3
   } sar_phase_t;

   function automatic int total_ticks(input int sync_n, input int res_n, input int tail_n);
      return sync_n + res_n + tail_n;
   endfunction
endpackage

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int RES_W    = 10,
   parameter int SYNC_CYC = 1,
   parameter int TAIL_CYC = 2,
   localparam int TOTAL   = total_ticks(SYNC_CYC, RES_W, TAIL_CYC),
   localparam int CNT_W   = $clog2(TOTAL + 1),
   localparam int IDX_W   = $clog2(RES_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             conv_tick,
   output logic             busy,
   output sar_phase_t       phase,
   output logic             ld_init,
   output logic             ld_decide,
   output logic [IDX_W-1:0] decide_idx,
   output logic             ld_store
);
   logic [CNT_W-1:0] cnt;
   logic             tick;
   int               rel;

   if (SYNC_CYC < 1) begin : g_bad_sync
      $error("SYNC_CYC must be at least 1");
   end
   if (TAIL_CYC < 1) begin : g_bad_tail
      $error("TAIL_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else if (conv_tick) begin
         if (cnt == CNT_W'(TOTAL - 1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      tick = busy & conv_tick;
      rel  = int'(cnt) - SYNC_CYC;
      if (!busy)                           phase = PH_IDLE;
      else if (int'(cnt) < SYNC_CYC)       phase = PH_SYNC;
      else if (rel < RES_W)                phase = PH_BITS;
      else                                 phase = PH_TAIL;
      ld_init    = tick && (phase == PH_SYNC) && (int'(cnt) == SYNC_CYC - 1);
      ld_decide  = tick && (phase == PH_BITS);
      decide_idx = (phase == PH_BITS) ? IDX_W'(RES_W - 1 - rel) : '0;
      ld_store   = tick && (cnt == CNT_W'(TOTAL - 1));
   end

   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_tick) |=> (busy && $stable(cnt)));
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
   parameter int RES_W  = 10,
   localparam int IDX_W = $clog2(RES_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_init,
   input  logic             ld_decide,
   input  logic [IDX_W-1:0] decide_idx,
   input  logic             cmp_ge,
   output logic [RES_W-1:0] trial
);
   if (RES_W < 2) begin : g_bad_res
      $error("RES_W must be at least 2");
   end

   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            trial[i] <= 1'b0;
         end else if (ld_init) begin
            trial[i] <= (i == RES_W - 1);
         end else if (ld_decide) begin
            if (decide_idx == IDX_W'(i))
               trial[i] <= cmp_ge;
            else if (decide_idx == IDX_W'(i + 1))
               trial[i] <= 1'b1;
         end
      end
   end

   p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_init && !ld_decide) |=> $stable(trial));
endmodule

// File: rtl/sar_out.sv
module sar_out #(
   parameter int RES_W = 10,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_store,
   input  logic [RES_W-1:0] code,
   input  logic             fmt_twos,
   input  logic             irq_ack,
   input  logic             flag_clr,
   output logic [OUT_W-1:0] result,
   output logic             done,
   output logic             irq_flag
);
   logic [OUT_W-1:0] fmt_right;
   logic [OUT_W-1:0] fmt_left;
   logic [RES_W-1:0] code_tc;

   if (OUT_W < RES_W) begin : g_bad_out
      $error("OUT_W must not be narrower than RES_W");
   end

   assign code_tc   = {~code[RES_W-1], code[RES_W-2:0]};
   assign fmt_right = OUT_W'(code);

   if (OUT_W == RES_W) begin : g_left_same
      assign fmt_left = code_tc;
   end else begin : g_left_pad
      assign fmt_left = {code_tc, {(OUT_W - RES_W){1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result   <= '0;
         done     <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         done <= ld_store;
         if (ld_store) begin
            result   <= fmt_twos ? fmt_left : fmt_right;
            irq_flag <= 1'b1;
         end else if (irq_ack || flag_clr) begin
            irq_flag <= 1'b0;
         end
      end
   end

   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_store |=> $stable(result));

   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> irq_flag);

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/sar_core.sv
module sar_core
   import sar_pkg::*;
#(
   parameter int RES_W    = 10,
   parameter int OUT_W    = 16,
   parameter int SYNC_CYC = 1,
   parameter int TAIL_CYC = 2,
   localparam int IDX_W   = $clog2(RES_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             conv_tick,
   input  logic             cmp_ge,
   input  logic             fmt_twos,
   input  logic             irq_ack,
   input  logic             flag_clr,
   output logic [RES_W-1:0] dac_code,
   output logic             busy,
   output logic             done,
   output logic [OUT_W-1:0] result,
   output logic             irq_flag
);
   sar_phase_t       phase;
   logic             ld_init;
   logic             ld_decide;
   logic             ld_store;
   logic [IDX_W-1:0] decide_idx;

   sar_seq #(
      .RES_W(RES_W), .SYNC_CYC(SYNC_CYC), .TAIL_CYC(TAIL_CYC)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .conv_tick(conv_tick),
      .busy(busy), .phase(phase), .ld_init(ld_init), .ld_decide(ld_decide),
      .decide_idx(decide_idx), .ld_store(ld_store)
   );

   sar_trial #(.RES_W(RES_W)) trial_i (
      .clk(clk), .rst_n(rst_n), .ld_init(ld_init), .ld_decide(ld_decide),
      .decide_idx(decide_idx), .cmp_ge(cmp_ge), .trial(dac_code)
   );

   sar_out #(.RES_W(RES_W), .OUT_W(OUT_W)) out_i (
      .clk(clk), .rst_n(rst_n), .ld_store(ld_store), .code(dac_code),
      .fmt_twos(fmt_twos), .irq_ack(irq_ack), .flag_clr(flag_clr),
      .result(result), .done(done), .irq_flag(irq_flag)
   );

   p_done_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_store_in_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_store |-> (phase == PH_TAIL));
endmodule

// File: tb/sar_core_tb.sv
module sar_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       conv_tick = 1'b0;
   logic       cmp_ge;
   logic       fmt_twos = 1'b0;
   logic       irq_ack = 1'b0;
   logic       flag_clr = 1'b0;
   logic [9:0] dac_code;
   logic       busy;
   logic       done;
   logic [15:0] result;
   logic       irq_flag;
   logic [9:0] vin = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign cmp_ge = (vin >= dac_code);

   sar_core dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .conv_tick(conv_tick),
      .cmp_ge(cmp_ge), .fmt_twos(fmt_twos), .irq_ack(irq_ack),
      .flag_clr(flag_clr), .dac_code(dac_code), .busy(busy), .done(done),
      .result(result), .irq_flag(irq_flag)
   );

   function automatic logic [15:0] exp_result(input logic [9:0] v, input bit f);
      return f ? {~v[9], v[8:0], 6'b0} : {6'b0, v};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic [9:0] v, input bit f, input int pct,
                           input bit poke, input bit ack_hold);
      int  ticks = 0;
      int  cyc = 0;
      bit  got = 0;
      bit  dac_bad = 0;
      bit  en;
      logic [9:0] prev;
      vin = v;
      fmt_twos = f;
      @(negedge clk);
      start = 1'b1;
      conv_tick = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      irq_ack = ack_hold;
      while (!got && cyc < 2000) begin
         en = ($urandom % 100) < pct;
         conv_tick = en;
         start = poke && (cyc == 5);
         prev = dac_code;
         @(negedge clk);
         cyc++;
         if (en) ticks++;
         else if (busy && dac_code != prev) dac_bad = 1;
         if (!got && !done && !busy) cyc = 3000;
         if (done) got = 1;
      end
      conv_tick = 1'b0;
      start = 1'b0;
      irq_ack = 1'b0;
      chk(got, "R2 done reached", got, 1);
      chk(ticks == 13, "R3 tick count", ticks, 13);
      chk(busy == 1'b0, "R3 busy low with done", busy, 0);
      chk(!dac_bad, "R5 dac moved without tick", dac_bad, 0);
      chk(result == exp_result(v, f), f ? "R7 R4 twos left" : "R6 R4 unsigned right",
          result, exp_result(v, f));
      chk(irq_flag == 1'b1, "R9 flag set on store", irq_flag, 1);
      @(negedge clk);
      chk(done == 1'b0, "R3 done single cycle", done, 0);
      if (poke) chk(busy == 1'b0, "R10 no second conversion", busy, 0);
   endtask

   initial begin
      logic [15:0] held;
      logic [9:0]  corners [6];
      corners = '{10'd0, 10'd1023, 10'd512, 10'd511, 10'd1, 10'd682};
      void'($urandom(32'd1234));
      #1;
      chk(busy == 0 && done == 0 && irq_flag == 0, "R1 reset controls",
          {busy, done, irq_flag}, 0);
      chk(result == 0 && dac_code == 0, "R1 reset data", result, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      foreach (corners[k]) begin
         run_conv(corners[k], 1'b0, 100, 1'b0, 1'b0);
         run_conv(corners[k], 1'b1, 40, 1'b0, 1'b0);
      end

      // R10: start pokes during conversion
      run_conv(10'h2a5, 1'b1, 100, 1'b1, 1'b0);
      run_conv(10'h13c, 1'b0, 30, 1'b1, 1'b0);

      // R9: acknowledge clears, software clear clears, store beats clear
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk(irq_flag == 1'b0, "R9 ack clears", irq_flag, 0);
      run_conv(10'h0f0, 1'b0, 70, 1'b0, 1'b0);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      chk(irq_flag == 1'b0, "R9 clr clears", irq_flag, 0);
      run_conv(10'h3c3, 1'b1, 100, 1'b0, 1'b1);

      // R8: idle activity leaves result alone
      held = result;
      for (int j = 0; j < 30; j++) begin
         @(negedge clk);
         conv_tick = $urandom % 2;
         fmt_twos = $urandom % 2;
         vin = 10'($urandom);
      end
      @(negedge clk);
      conv_tick = 1'b0;
      chk(result == held, "R8 result held while idle", result, held);
      chk(busy == 1'b0 && done == 1'b0, "R8 no activity while idle", {busy, done}, 0);

      for (int n = 0; n < 40; n++)
         run_conv(10'($urandom), 1'($urandom), 20 + ($urandom % 81), 1'($urandom), 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule